// File: doc/BRIEF.md
# Streaming 3x3 Rank Order Filter

This block filters a raster stream of unsigned 8-bit grayscale pixels. It takes one pixel per clock and keeps the two previous image rows in internal line buffers. From these it forms the 3x3 neighbourhood centred on each origin pixel. A pipelined compare-and-swap network puts the nine values into ascending order, and the block outputs the entry at a chosen rank. The datapath uses comparisons and multiplexers only.

The same hardware gives several filters. Rank 1 gives a flat grayscale erosion (minimum), rank 5 a median filter, and rank 9 a flat grayscale dilation (maximum). The rank is taken from `in_order` on the start-of-frame pixel, so it cannot change within a frame.

Each frame produces exactly as many output pixels as it has input pixels. Origins on the outer rows and columns have no full window, so they pass through unchanged. Because each window needs pixels from one row ahead, the last row of a frame comes out during an internal drain. The drain needs `IMG_W+1` idle input cycles after the last pixel of a frame, before the next start of frame.

Top module: `rank_filter3x3`

## Requirements
- R1: While `rst_n` is low, and after reset until the first result, `out_valid`, `out_sof` and `out_eol` are low and `out_pix` is 0.
- R2: Each frame of `IMG_W` x `IMG_H` input pixels yields exactly `IMG_W*IMG_H` valid outputs, in raster order. `out_sof` is high only with the output for origin row 0, column 0. `out_eol` is high with every output whose origin is in column `IMG_W-1`.
- R3: For an origin that is not on the border, the output is entry k (1 = smallest) of the nine values of the 3x3 window centred on that origin, sorted in ascending order. k is the rank latched for the frame.
- R4: Rank 5 gives the median. A window holding 10,20,...,90 in any arrangement gives 50.
- R5: Rank 1 outputs the window minimum, and rank 9 outputs the window maximum.
- R6: An origin in row 0, row `IMG_H-1`, column 0 or column `IMG_W-1` outputs its own input pixel unchanged, with `out_valid` high.
- R7: The rank is sampled from `in_order` only on the pixel that carries `in_sof`. Values on `in_order` at other pixels have no effect. Outputs of the previous frame that are still in the pipeline keep that frame's rank.
- R8: `in_order` = 0 is treated as rank 1, and any value from 10 to 15 is treated as rank 9.
- R9: A pixel is accepted on every cycle with `in_valid` high, with no stall. The output for origin (0,0) appears `IMG_W+11` clock edges after the edge that accepts the start-of-frame pixel. The frame's remaining outputs then follow on consecutive cycles, provided the input pixels arrive on consecutive cycles.
- R10: A pixel with `in_valid` high and `in_sof` high starts a frame at row 0, column 0. Pixels with `in_valid` high before any start of frame, or after a frame's last pixel, are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | PIX_W | Input grayscale pixel |
| in_order | input | 4 | Rank request, sampled at start of frame |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sof | output | 1 | Output is origin (0,0) of its frame |
| out_eol | output | 1 | Output origin is in the last column |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
Two functions can fall in the same cycle: a new frame can latch its rank while the tail of the previous frame is still moving through the sorting pipeline. The bench provokes this by sending two frames separated by only the minimum gap, with opposite ranks (1 then 9). Every output of both frames is compared against a sort-based model that uses each frame's own rank. Any mix-up of ranks shows up in the last rows of the first frame. The table-driven frames also change `in_order` on every pixel except the first, which checks that the mid-frame value is ignored.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int WIN_N  = 9;
  localparam int ORD_W  = 4;
  localparam int RANK_W = 4;

  // Requested order 1..9 -> zero-based rank index; 0 maps to 1, >9 maps to 9.
  function automatic logic [RANK_W-1:0] rank_of_order(input logic [ORD_W-1:0] ord);
    if (ord == '0)
      return '0;
    else if (ord > ORD_W'(WIN_N))
      return RANK_W'(WIN_N - 1);
    else
      return RANK_W'(ord - ORD_W'(1));
  endfunction

  function automatic logic on_border(input int r, input int c, input int h, input int w);
    return (r == 0) || (c == 0) || (r == h - 1) || (c == w - 1);
  endfunction
endpackage

// File: rtl/rf_window.sv
module rf_window
  import rf_pkg::*;
#(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [PIX_W-1:0]       in_pix,
  input  logic [ORD_W-1:0]       in_order,
  output logic [WIN_N*PIX_W-1:0] win_flat,
  output logic                   org_fire,
  output logic                   org_border,
  output logic                   org_sof,
  output logic                   org_eol,
  output logic [RANK_W-1:0]      org_rank,
  output logic [PIX_W-1:0]       org_center,
  output logic                   sof_acc,
  output logic [RANK_W-1:0]      rank_q
);
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int RW = $clog2(IMG_H + 2);

  logic [PIX_W-1:0] lb_prev [IMG_W];
  logic [PIX_W-1:0] lb_old  [IMG_W];
  logic [PIX_W-1:0] win [3][3];

  logic [CW-1:0] sc_q, pos_c, oc_q;
  logic [RW-1:0] sr_q, pos_r, or_q;
  logic          frame_q, drain_q, org_on_q;
  logic          acc, shift, org_en, last_in, last_org, col_end;
  logic [PIX_W-1:0] newpix;

  assign acc     = in_valid && (in_sof || frame_q);
  assign sof_acc = acc && in_sof;
  assign shift   = acc || drain_q;
  assign pos_c   = sof_acc ? '0 : sc_q;
  assign pos_r   = sof_acc ? '0 : sr_q;
  assign newpix  = acc ? in_pix : '0;
  assign col_end = (pos_c == CW'(IMG_W - 1));
  assign org_en  = shift && !sof_acc &&
                   (org_on_q || (pos_r == RW'(1) && pos_c == CW'(1)));
  assign last_in  = acc && (pos_r == RW'(IMG_H - 1)) && col_end;
  assign last_org = org_en && (or_q == RW'(IMG_H - 1)) && (oc_q == CW'(IMG_W - 1));

  // Line buffers and window shift; data registers carry no reset.
  always_ff @(posedge clk) begin
    if (shift) begin
      lb_old[pos_c]  <= lb_prev[pos_c];
      lb_prev[pos_c] <= newpix;
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
      end
      win[0][2] <= lb_old[pos_c];
      win[1][2] <= lb_prev[pos_c];
      win[2][2] <= newpix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q       <= '0;
      sr_q       <= '0;
      oc_q       <= '0;
      or_q       <= '0;
      frame_q    <= 1'b0;
      drain_q    <= 1'b0;
      org_on_q   <= 1'b0;
      rank_q     <= '0;
      org_fire   <= 1'b0;
      org_border <= 1'b0;
      org_sof    <= 1'b0;
      org_eol    <= 1'b0;
      org_rank   <= '0;
    end else begin
      org_fire <= org_en;
      if (org_en) begin
        org_border <= on_border(int'(or_q), int'(oc_q), IMG_H, IMG_W);
        org_sof    <= (or_q == '0) && (oc_q == '0);
        org_eol    <= (oc_q == CW'(IMG_W - 1));
        org_rank   <= rank_q;
      end
      if (shift) begin
        sc_q <= col_end ? '0 : pos_c + CW'(1);
        sr_q <= col_end ? pos_r + RW'(1) : pos_r;
      end
      if (sof_acc) begin
        frame_q  <= 1'b1;
        drain_q  <= 1'b0;
        org_on_q <= 1'b0;
        oc_q     <= '0;
        or_q     <= '0;
        rank_q   <= rank_of_order(in_order);
      end
      if (last_in) begin
        frame_q <= 1'b0;
        drain_q <= 1'b1;
      end
      if (org_en) begin
        org_on_q <= 1'b1;
        if (oc_q == CW'(IMG_W - 1)) begin
          oc_q <= '0;
          or_q <= or_q + RW'(1);
        end else begin
          oc_q <= oc_q + CW'(1);
        end
      end
      if (last_org) begin
        drain_q  <= 1'b0;
        org_on_q <= 1'b0;
      end
    end
  end

  assign org_center = win[1][1];

  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      assign win_flat[(r*3+c)*PIX_W +: PIX_W] = win[r][c];
    end
  end
endmodule

// File: rtl/rf_sortnet.sv
module rf_sortnet #(
  parameter int N   = 9,
  parameter int DW  = 8,
  parameter int SBW = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [N*DW-1:0] in_data,
  input  logic [SBW-1:0]  in_sb,
  output logic            out_vld,
  output logic [N*DW-1:0] out_data,
  output logic [SBW-1:0]  out_sb
);
  localparam int NS = N;   // odd-even transposition: N rounds sort N keys

  logic [DW-1:0]  lv   [NS+1][N];
  logic [DW-1:0]  st_d [NS][N];
  logic [DW-1:0]  st_q [NS][N];
  logic [SBW-1:0] sb_q [NS];
  logic [NS-1:0]  vld_q;

  always_comb begin
    for (int i = 0; i < N; i++) lv[0][i] = in_data[i*DW +: DW];
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < N; i++) lv[s+1][i] = st_q[s][i];
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < N; i++) st_d[s][i] = lv[s][i];
      for (int i = s % 2; i + 1 < N; i += 2) begin
        if (lv[s][i] > lv[s][i+1]) begin
          st_d[s][i]   = lv[s][i+1];
          st_d[s][i+1] = lv[s][i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    st_q    <= st_d;
    sb_q[0] <= in_sb;
    for (int s = 1; s < NS; s++) sb_q[s] <= sb_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[NS-2:0], in_vld};
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign out_data[i*DW +: DW] = st_q[NS-1][i];
  end
  assign out_sb  = sb_q[NS-1];
  assign out_vld = vld_q[NS-1];
endmodule

// File: rtl/rank_filter3x3.sv
module rank_filter3x3
  import rf_pkg::*;
#(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [3:0]       in_order,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [PIX_W-1:0] out_pix
);
  localparam int SBW = PIX_W + RANK_W + 3;

  logic [WIN_N*PIX_W-1:0] win_flat, srt_data;
  logic                   org_fire, org_border, org_sof, org_eol, sof_acc;
  logic [RANK_W-1:0]      org_rank, rank_q, s_rank;
  logic [PIX_W-1:0]       org_center, s_center, picked;
  logic [SBW-1:0]         sb_in, srt_sb;
  logic                   srt_vld, s_border, s_eol, s_sof;

  rf_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_pix(in_pix), .in_order(in_order), .win_flat(win_flat),
    .org_fire(org_fire), .org_border(org_border), .org_sof(org_sof),
    .org_eol(org_eol), .org_rank(org_rank), .org_center(org_center),
    .sof_acc(sof_acc), .rank_q(rank_q)
  );

  assign sb_in = {org_sof, org_eol, org_border, org_rank, org_center};

  rf_sortnet #(.N(WIN_N), .DW(PIX_W), .SBW(SBW)) u_sort (
    .clk(clk), .rst_n(rst_n), .in_vld(org_fire), .in_data(win_flat),
    .in_sb(sb_in), .out_vld(srt_vld), .out_data(srt_data), .out_sb(srt_sb)
  );

  assign s_center = srt_sb[PIX_W-1:0];
  assign s_rank   = srt_sb[PIX_W +: RANK_W];
  assign s_border = srt_sb[PIX_W+RANK_W];
  assign s_eol    = srt_sb[PIX_W+RANK_W+1];
  assign s_sof    = srt_sb[PIX_W+RANK_W+2];
  assign picked   = srt_data[s_rank*PIX_W +: PIX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= srt_vld;
      out_sof   <= srt_vld && s_sof;
      out_eol   <= srt_vld && s_eol;
      if (srt_vld) out_pix <= s_border ? s_center : picked;
    end
  end
endmodule

// File: rtl/rank_filter3x3_chk.sv
module rank_filter3x3_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             org_fire,
  input logic             org_border,
  input logic [PIX_W-1:0] org_center,
  input logic             sof_acc,
  input logic [3:0]       rank_q,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eol,
  input logic [PIX_W-1:0] out_pix
);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(org_fire, 10));

  p_border_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(org_border, 10)) |-> out_pix == $past(org_center, 10));

  p_sof_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  p_eol_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  p_sof_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof);

  p_rank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_acc |=> $stable(rank_q));

  p_rank_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rank_q <= 4'd8);
endmodule

bind rank_filter3x3 rank_filter3x3_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .org_fire(org_fire), .org_border(org_border),
  .org_center(org_center), .sof_acc(sof_acc), .rank_q(rank_q),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
);

// File: tb/rank_filter3x3_tb.sv
`timescale 1ns/1ps
module rank_filter3x3_tb;
  localparam int W = 6, H = 5, NPIX = W * H, CAP = 512;

  typedef struct packed {
    logic [3:0] ord;
    logic [1:0] pat;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd5,  2'd0, 8'd50, 4'd4},
    '{4'd1,  2'd0, 8'd10, 4'd5},
    '{4'd9,  2'd0, 8'd90, 4'd5},
    '{4'd0,  2'd0, 8'd10, 4'd8},
    '{4'd13, 2'd0, 8'd90, 4'd8},
    '{4'd3,  2'd0, 8'd30, 4'd3},
    '{4'd5,  2'd1, 8'd0,  4'd3},
    '{4'd2,  2'd2, 8'd0,  4'd3},
    '{4'd8,  2'd3, 8'd0,  4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic [3:0] in_order = '0;
  logic out_valid, out_sof, out_eol;
  logic [7:0] out_pix;

  int checks = 0, errors = 0, cyc = 0, ncap = 0, sof_cyc = 0;
  logic [7:0] cap_pix [CAP];
  logic       cap_sof [CAP];
  logic       cap_eol [CAP];
  int         cap_cyc [CAP];

  rank_filter3x3 #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_pix(in_pix), .in_order(in_order), .out_valid(out_valid),
    .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && ncap < CAP) begin
      cap_pix[ncap] <= out_pix;
      cap_sof[ncap] <= out_sof;
      cap_eol[ncap] <= out_eol;
      cap_cyc[ncap] <= cyc;
      ncap <= ncap + 1;
    end
  end

  function automatic string req_tag(input logic [3:0] r);
    case (r)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] pix_of(input int pat, input int r, input int c);
    int v;
    case (pat)
      0: begin
        if (r >= 1 && r <= 3 && c >= 1 && c <= 3) begin
          case ((r - 1) * 3 + (c - 1))
            0: v = 70; 1: v = 20; 2: v = 90;
            3: v = 40; 4: v = 10; 5: v = 60;
            6: v = 30; 7: v = 80; default: v = 50;
          endcase
        end else v = (r * 37 + c * 11 + 5) % 256;
      end
      1: v = (r * 53 + c * 29 + 7) % 256;
      2: v = (r == 2 && c == 3) ? 255 : (r == 1 && c == 1) ? 0 :
             (r == 3 && c == 2) ? 200 : 128;
      default: v = 255 - (r * W + c) * 8;
    endcase
    return 8'(v);
  endfunction

  function automatic int rank_ref(input logic [3:0] ord);
    if (ord == 0) return 0;
    if (ord > 9) return 8;
    return int'(ord) - 1;
  endfunction

  function automatic logic [7:0] exp_pix(input int pat, input int r, input int c, input int rk);
    logic [7:0] a [9];
    logic [7:0] t;
    int n;
    if (r == 0 || c == 0 || r == H - 1 || c == W - 1) return pix_of(pat, r, c);
    n = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        a[n] = pix_of(pat, r + dr, c + dc);
        n++;
      end
    for (int i = 1; i < 9; i++)
      for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
        t = a[j]; a[j] = a[j-1]; a[j-1] = t;
      end
    return a[rk];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame; in_order carries a different value after the first pixel.
  task automatic send_frame(input int pat, input logic [3:0] ord);
    for (int k = 0; k < NPIX; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_pix   = pix_of(pat, k / W, k % W);
      in_order = (k == 0) ? ord : ~ord;
      if (k == 0) sof_cyc = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    repeat (W) @(negedge clk);
  endtask

  task automatic check_frame(input int base, input int pat, input int rk, input string req);
    for (int k = 0; k < NPIX; k++) begin
      int r, c;
      logic [7:0] e;
      r = k / W;
      c = k % W;
      e = exp_pix(pat, r, c, rk);
      if (r == 0 || c == 0 || r == H - 1 || c == W - 1)
        chk(cap_pix[base+k] == e, "R6", int'(cap_pix[base+k]), int'(e));
      else
        chk(cap_pix[base+k] == e, req, int'(cap_pix[base+k]), int'(e));
      chk(cap_sof[base+k] == (k == 0), "R2", int'(cap_sof[base+k]), int'(k == 0));
      chk(cap_eol[base+k] == (c == W - 1), "R2", int'(cap_eol[base+k]), int'(c == W - 1));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && out_pix == 0, "R1", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_sof && !out_eol && out_pix == 0, "R1", int'(out_valid), 0);

    // R10: stray pixels with no frame started
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_pix = 8'(k * 40);
    end
    @(negedge clk);
    in_valid = 1'b0;
    idle(20);
    chk(ncap == 0, "R10", ncap, 0);

    for (int v = 0; v < NV; v++) begin
      base = ncap;
      send_frame(int'(VECS[v].pat), VECS[v].ord);
      idle(14);
      chk(ncap - base == NPIX, "R2", ncap - base, NPIX);
      check_frame(base, int'(VECS[v].pat), rank_ref(VECS[v].ord), req_tag(VECS[v].req));
      if (VECS[v].pat == 2'd0)
        chk(cap_pix[base+2*W+2] == VECS[v].expv, req_tag(VECS[v].req),
            int'(cap_pix[base+2*W+2]), int'(VECS[v].expv));
      chk(cap_cyc[base] - sof_cyc == W + 12, "R9", cap_cyc[base] - sof_cyc, W + 12);
      chk(cap_cyc[base+NPIX-1] - cap_cyc[base] == NPIX - 1, "R9",
          cap_cyc[base+NPIX-1] - cap_cyc[base], NPIX - 1);
    end

    // R7: next frame latches a new rank while the previous tail is in flight
    base = ncap;
    send_frame(1, 4'd1);
    send_frame(3, 4'd9);
    idle(14);
    chk(ncap - base == 2 * NPIX, "R2", ncap - base, 2 * NPIX);
    check_frame(base, 1, 0, "R7");
    check_frame(base + NPIX, 3, 8, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule